// File: doc/BRIEF.md
# Muxed I/O Pad Cell

This block is a single pad slice of a pin multiplexer. A small select register decides which of `N_FN` peripheral functions owns the pad. The selected function supplies the pad's drive value and drive enable. The pad's received value is handed back only to the selected function, and only if that function can accept input.

Each function slot has a fixed kind, set at build time by the `FN_TYPES` parameter. The kind is one of: unassigned, input-only, output-only or bidirectional. Slot 0 is always the GPIO function. An output-only function has no enable of its own, so its drive enable is borrowed from the GPIO slot. Software can then turn many pads into outputs at once by setting GPIO direction bits, without touching each pad's select register. A select value past the last populated slot falls through to the last slot.

Setting `DEDICATED` builds a pass-through variant: slot 0 is wired straight to the pad, there is no select register, and the select write port is ignored. All pad paths are combinational from the current select value and the function signals. The interface is plain control and data with no valid/ready handshake. The pad and the functions are always live, so there is nothing to back-pressure.

Top module: `padmux_cell`

## Requirements
- R1: After reset the select register `sel_q` reads 0, which is the GPIO slot.
- R2: When `sel_we` is high at a rising clock edge, `sel_q` takes `sel_wdata` from that edge on. While `sel_we` is low, `sel_q` keeps its value.
- R3: `FN_TYPES` bits [2i+1:2i] give the kind of slot i: 0 means unassigned, 1 input-only, 2 output-only, 3 bidirectional. Slot 0 is GPIO. When a bidirectional slot i is selected, `pad_out` equals `fn_out[i]` and `pad_oe` equals `fn_oe[i]`.
- R4: When an output-only slot i is selected, `pad_out` equals `fn_out[i]` and `pad_oe` equals `fn_oe[0]`, the GPIO enable.
- R5: When an unassigned slot or an input-only slot is selected, `pad_out` and `pad_oe` are both 0.
- R6: A select value of `N_FN` or more behaves exactly like a select of `N_FN-1`, on both the output paths and the input path.
- R7: `fn_in[i]` equals `pad_in` only when slot i is the selected slot and is input-only or bidirectional. Every other bit of `fn_in` is 0.
- R8: With `DEDICATED`=1, the cell behaves as if slot 0 were always selected. `sel_q` stays 0, and writes on `sel_we`/`sel_wdata` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the select register |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_we | input | 1 | Select register write strobe |
| sel_wdata | input | SW | New select value |
| sel_q | output | SW | Current select value |
| fn_out | input | N_FN | Per-slot drive value |
| fn_oe | input | N_FN | Per-slot drive enable |
| fn_in | output | N_FN | Per-slot received value |
| pad_out | output | 1 | Pad drive value |
| pad_oe | output | 1 | Pad drive enable |
| pad_in | input | 1 | Value received from the pad |

## Verification
The outbound drive path and the inbound receive path are active in the same cycle. Both are checked together for every select value, including out-of-range values.

The bench holds a select value and sweeps every combination of `fn_out`, `fn_oe` and `pad_in`. At each step it compares `pad_out`, `pad_oe` and all of `fn_in` at once, against values computed from the slot-kind table. Select writes are checked on the cycle after the edge. The bench also checks that an idle strobe with changing write data leaves the selection, and so both paths, unchanged.

// File: rtl/padmux_pkg.sv
package padmux_pkg;
  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_IN    = 2'd1,
    KIND_OUT   = 2'd2,
    KIND_INOUT = 2'd3
  } slot_kind_t;

  function automatic bit kind_drives(logic [1:0] k);
    return (k == KIND_OUT) || (k == KIND_INOUT);
  endfunction

  function automatic bit kind_receives(logic [1:0] k);
    return (k == KIND_IN) || (k == KIND_INOUT);
  endfunction
endpackage

// File: rtl/padmux_sel.sv
module padmux_sel #(
  parameter int N_FN = 5,
  parameter bit DEDICATED = 1'b0,
  localparam int SW = (N_FN > 1) ? $clog2(N_FN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_we,
  input  logic [SW-1:0] sel_wdata,
  output logic [SW-1:0] sel_q,
  output logic [SW-1:0] slot_idx
);
  localparam logic [SW-1:0] LAST = SW'(N_FN - 1);

  generate
    if (DEDICATED) begin : g_fixed
      assign sel_q    = '0;
      assign slot_idx = '0;
    end else begin : g_reg
      logic [SW-1:0] sel_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel_r <= '0;
        else if (sel_we) sel_r <= sel_wdata;
      end
      assign sel_q    = sel_r;
      // ordered compare: anything past the last slot falls to the last slot
      assign slot_idx = (sel_r > LAST) ? LAST : sel_r;
    end
  endgenerate
endmodule

// File: rtl/padmux_out_path.sv
module padmux_out_path
  import padmux_pkg::*;
#(
  parameter int N_FN = 5,
  parameter logic [2*N_FN-1:0] FN_TYPES = '0,
  localparam int SW = (N_FN > 1) ? $clog2(N_FN) : 1
) (
  input  logic [SW-1:0]   slot_idx,
  input  logic [N_FN-1:0] fn_out,
  input  logic [N_FN-1:0] fn_oe,
  output logic            pad_out,
  output logic            pad_oe
);
  logic [N_FN-1:0] cand_out;
  logic [N_FN-1:0] cand_oe;

  for (genvar i = 0; i < N_FN; i++) begin : g_slot
    localparam logic [1:0] K = FN_TYPES[2*i +: 2];
    if (K == KIND_INOUT) begin : g_io
      assign cand_out[i] = fn_out[i];
      assign cand_oe[i]  = fn_oe[i];
    end else if (K == KIND_OUT) begin : g_o
      assign cand_out[i] = fn_out[i];
      assign cand_oe[i]  = fn_oe[0];  // enable borrowed from GPIO slot
    end else begin : g_zero
      assign cand_out[i] = 1'b0;
      assign cand_oe[i]  = 1'b0;
    end
  end

  always_comb begin
    pad_out = 1'b0;
    pad_oe  = 1'b0;
    for (int i = 0; i < N_FN; i++) begin
      if (slot_idx == SW'(i)) begin
        pad_out = cand_out[i];
        pad_oe  = cand_oe[i];
      end
    end
  end
endmodule

// File: rtl/padmux_in_path.sv
module padmux_in_path
  import padmux_pkg::*;
#(
  parameter int N_FN = 5,
  parameter logic [2*N_FN-1:0] FN_TYPES = '0,
  localparam int SW = (N_FN > 1) ? $clog2(N_FN) : 1
) (
  input  logic [SW-1:0]   slot_idx,
  input  logic            pad_in,
  output logic [N_FN-1:0] fn_in
);
  for (genvar i = 0; i < N_FN; i++) begin : g_slot
    localparam logic [1:0] K = FN_TYPES[2*i +: 2];
    if (kind_receives(K)) begin : g_rx
      assign fn_in[i] = (slot_idx == SW'(i)) & pad_in;
    end else begin : g_none
      assign fn_in[i] = 1'b0;
    end
  end
endmodule

// File: rtl/padmux_cell.sv
module padmux_cell
  import padmux_pkg::*;
#(
  parameter int N_FN = 5,
  parameter logic [2*N_FN-1:0] FN_TYPES = 10'b11_00_01_10_11,
  parameter bit DEDICATED = 1'b0,
  localparam int SW = (N_FN > 1) ? $clog2(N_FN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_we,
  input  logic [SW-1:0]   sel_wdata,
  output logic [SW-1:0]   sel_q,
  input  logic [N_FN-1:0] fn_out,
  input  logic [N_FN-1:0] fn_oe,
  output logic [N_FN-1:0] fn_in,
  output logic            pad_out,
  output logic            pad_oe,
  input  logic            pad_in
);
  logic [SW-1:0] slot_idx;

  padmux_sel #(.N_FN(N_FN), .DEDICATED(DEDICATED)) u_sel (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
    .sel_q(sel_q), .slot_idx(slot_idx)
  );

  padmux_out_path #(.N_FN(N_FN), .FN_TYPES(FN_TYPES)) u_out (
    .slot_idx(slot_idx), .fn_out(fn_out), .fn_oe(fn_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  padmux_in_path #(.N_FN(N_FN), .FN_TYPES(FN_TYPES)) u_in (
    .slot_idx(slot_idx), .pad_in(pad_in), .fn_in(fn_in)
  );
endmodule

// File: rtl/padmux_cell_chk.sv
module padmux_cell_chk
  import padmux_pkg::*;
#(
  parameter int N_FN = 5,
  parameter logic [2*N_FN-1:0] FN_TYPES = '0,
  parameter bit DEDICATED = 1'b0,
  localparam int SW = (N_FN > 1) ? $clog2(N_FN) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sel_we,
  input logic [SW-1:0]   sel_wdata,
  input logic [SW-1:0]   sel_q,
  input logic [N_FN-1:0] fn_out,
  input logic [N_FN-1:0] fn_oe,
  input logic [N_FN-1:0] fn_in,
  input logic            pad_out,
  input logic            pad_oe,
  input logic            pad_in
);
  localparam logic [1:0] KL = FN_TYPES[2*(N_FN-1) +: 2];

  // R7: at most one function receives the pad value
  p_in_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fn_in));

  if (DEDICATED) begin : g_ded
    p_fixed_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sel_q == '0);
  end else begin : g_mux
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_we |=> sel_q == $past(sel_wdata));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_we |=> $stable(sel_q));
    if (KL == KIND_INOUT) begin : g_last_io
      p_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel_q) >= N_FN) |-> (pad_out == fn_out[N_FN-1] && pad_oe == fn_oe[N_FN-1]));
    end
  end

  for (genvar i = 0; i < N_FN; i++) begin : g_slot
    localparam logic [1:0] K = FN_TYPES[2*i +: 2];
    if (K == KIND_OUT) begin : g_o
      p_gpio_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel_q) == i) |-> (pad_oe == fn_oe[0] && pad_out == fn_out[i]));
    end else if (K == KIND_INOUT) begin : g_io
      p_own_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel_q) == i) |-> (pad_oe == fn_oe[i] && pad_out == fn_out[i]));
    end else begin : g_quiet
      p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel_q) == i) |-> (!pad_oe && !pad_out));
    end
  end
endmodule

bind padmux_cell padmux_cell_chk #(.N_FN(N_FN), .FN_TYPES(FN_TYPES), .DEDICATED(DEDICATED)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata), .sel_q(sel_q),
  .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in), .pad_out(pad_out), .pad_oe(pad_oe),
  .pad_in(pad_in)
);

// File: tb/sim_padmux_cell.sv
module sim_padmux_cell;
  localparam int CLK_PERIOD = 10;
  localparam int N = 5;
  localparam int SW = 3;
  localparam logic [2*N-1:0] TYPES = 10'b11_00_01_10_11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_we = 1'b0;
  logic [SW-1:0] sel_wdata = '0;
  logic [SW-1:0] sel_q;
  logic [N-1:0] fn_out = '0, fn_oe = '0, fn_in;
  logic pad_out, pad_oe, pad_in = 1'b0;

  logic d_we = 1'b0, d_wdata = 1'b0, d_q, d_fin, d_out, d_oe;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  padmux_cell #(.N_FN(N), .FN_TYPES(TYPES), .DEDICATED(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata), .sel_q(sel_q),
    .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_in(pad_in)
  );

  // dedicated variant: one input-only slot
  padmux_cell #(.N_FN(1), .FN_TYPES(2'b01), .DEDICATED(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .sel_we(d_we), .sel_wdata(d_wdata), .sel_q(d_q),
    .fn_out(1'b1), .fn_oe(1'b1), .fn_in(d_fin), .pad_out(d_out), .pad_oe(d_oe),
    .pad_in(pad_in)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected {fn_in, pad_oe, pad_out} from the slot table
  function automatic logic [N+1:0] model(int s, logic [N-1:0] fo, logic [N-1:0] fe, logic pi);
    int e;
    logic [1:0] k;
    logic o, oe;
    logic [N-1:0] fi;
    e = (s >= N) ? N-1 : s;
    k = TYPES[2*e +: 2];
    o = 1'b0; oe = 1'b0; fi = '0;
    if (k == 2'd3) begin o = fo[e]; oe = fe[e]; end
    else if (k == 2'd2) begin o = fo[e]; oe = fe[0]; end
    if (k == 2'd1 || k == 2'd3) fi[e] = pi;
    return {fi, oe, o};
  endfunction

  task automatic write_sel(logic [SW-1:0] v);
    @(negedge clk);
    sel_we = 1'b1; sel_wdata = v;
    @(negedge clk);
    sel_we = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    fn_out = 5'b00001; fn_oe = 5'b00001; pad_in = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset select", sel_q, 0);
    check("R1 reset drives GPIO", {fn_in, pad_oe, pad_out}, model(0, fn_out, fn_oe, pad_in));

    for (int s = 0; s < 8; s++) begin
      write_sel(SW'(s));
      check("R2 select load", sel_q, s);
      for (int p = 0; p < 2048; p++) begin
        fn_out = p[4:0]; fn_oe = p[9:5]; pad_in = p[10];
        #1;
        if (s >= N)
          check("R6 out-of-range select", {fn_in, pad_oe, pad_out}, model(s, fn_out, fn_oe, pad_in));
        else
          check("R3 R4 R5 R7 slot paths", {fn_in, pad_oe, pad_out}, model(s, fn_out, fn_oe, pad_in));
      end
    end

    // R2 hold: idle strobe with changing data
    write_sel(3'd1);
    @(negedge clk);
    sel_wdata = 3'd3;
    @(negedge clk);
    sel_wdata = 3'd0;
    @(negedge clk);
    fn_out = 5'b00010; fn_oe = 5'b00001;
    #1;
    check("R2 hold select", sel_q, 1);
    check("R4 out-only borrows GPIO enable", {pad_oe, pad_out}, 2'b11);
    fn_oe = 5'b00010;
    #1;
    check("R4 own enable ignored", {pad_oe, pad_out}, 2'b01);

    // R8 dedicated variant
    @(negedge clk);
    d_we = 1'b1; d_wdata = 1'b1;
    @(negedge clk);
    d_we = 1'b0;
    for (int b = 0; b < 2; b++) begin
      pad_in = b[0];
      #1;
      check("R8 dedicated select fixed", d_q, 0);
      check("R8 dedicated pass-through", {d_fin, d_oe, d_out}, {b[0], 2'b00});
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule